// File: doc/BRIEF.md
# Vector Unit Control Register Access

This block holds the vector unit's control/status word and a fixed implementation word. It serves the two register-transfer instructions that move values between the general-purpose register file and those control words. A write gives an index and a GPR-width value. Index 1 stores the value through a mask that keeps only the defined fields. Every other index, index 0 included, is ignored on write. A read gives an index and returns a GPR-width value in the same cycle, and that read needs no clock.

The stored word drives three controls toward the arithmetic units at all times: a translated rounding mode, an output flush-to-zero and an input flush-to-zero. Every write to index 1 also looks at the cause bits it has just written. If any cause is enabled, or if the unimplemented-operation cause is set, the block gives a one-cycle trap pulse. The value is stored whether or not the trap fires. The floating-point datapath and the exception vectoring are outside this block.

Top module: `vcr_ctl_access`

## Requirements
- R1: During reset and right after it, the stored word is zero. This makes a read of index 1 return 0, `round_mode` 2'b00, both flush outputs 0 and `trap` 0.
- R2: A write with `wr_idx`=1 stores `wr_data` AND 0x0103FFFF at the next rising edge. The defined fields are rounding [1:0], flags [6:2], enables [11:7], causes [17:12] and flush bit 24. Every other bit reads back as zero.
- R3: A write with any `wr_idx` other than 1, index 0 included, leaves the stored word unchanged.
- R4: Reads are combinational from `rd_idx`. Index 0 returns parameter `IMPL_VALUE` and index 1 returns the stored word, zero-extended. Any other index returns zero. A read of index 1 in the same cycle as a write returns the value stored before that write.
- R5: The `round_mode` output translates the stored field [1:0]. Field 0 (nearest-even) gives 2'b00, field 1 (toward zero) gives 2'b11, field 2 (toward +inf) gives 2'b10 and field 3 (toward -inf) gives 2'b01.
- R6: Stored bit 24 drives both `flush_out` and `flush_in`. They take the new value in the cycle after the write.
- R7: `trap` is high in the cycle after an index-1 write when the written causes [17:12] AND'ed with {1, enables [11:7]} are nonzero. Cause bit 12+i pairs with enable bit 7+i for i in 0..4. Cause bit 17, the unimplemented operation, traps with no enable.
- R8: A write that traps still stores its value.
- R9: `trap` is low unless the previous cycle held an index-1 write that met R7. A single trapping write gives a pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_idx | input | IDX_W | Control word index for the write |
| wr_data | input | GPR_W | Value from the GPR side |
| rd_idx | input | IDX_W | Control word index for the read |
| rd_data | output | GPR_W | Read result toward the GPR side |
| round_mode | output | 2 | Translated rounding mode for the arithmetic units |
| flush_out | output | 1 | Flush subnormal results to zero |
| flush_in | output | 1 | Flush subnormal operands to zero |
| trap | output | 1 | One-cycle exception trap request |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a read of index 1 and a write of index 1. The bench drives both in one cycle and expects the old word on `rd_data`. It expects the new word one cycle later.

The second pair is the trap decision and the commit of the stored word, which both land on the same edge. The bench writes trapping values and then reads them back while `trap` is high. It also sends two trapping writes back to back and expects `trap` to stay high for two cycles, not to be merged or dropped.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
   // Stored control word layout
   localparam int CSR_W      = 25;
   localparam int RM_LSB     = 0;
   localparam int FLAG_LSB   = 2;
   localparam int EN_LSB     = 7;
   localparam int CAUSE_LSB  = 12;
   localparam int N_EN       = 5;
   localparam int N_CAUSE    = N_EN + 1;  // top cause is unimplemented op
   localparam int FLUSH_BIT  = 24;
   localparam int CAUSE_MSB  = CAUSE_LSB + N_CAUSE - 1;

   localparam logic [CSR_W-1:0] CSR_MASK =
      (CSR_W'(1) << FLUSH_BIT) | ((CSR_W'(1) << (CAUSE_MSB + 1)) - CSR_W'(1));

   // Rounding encoding seen by the arithmetic units
   typedef enum logic [1:0] {
      ARM_NEAR_EVEN = 2'b00,
      ARM_TO_MINUS  = 2'b01,
      ARM_TO_PLUS   = 2'b10,
      ARM_TO_ZERO   = 2'b11
   } arith_rm_e;
endpackage

// File: rtl/vcr_csr_store.sv
module vcr_csr_store
   import vcr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [CSR_W-1:0] wr_val,
   output logic [CSR_W-1:0] csr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      csr_q <= '0;
      else if (commit) csr_q <= wr_val & CSR_MASK;
   end
endmodule

// File: rtl/vcr_round_xlate.sv
module vcr_round_xlate
   import vcr_pkg::*;
(
   input  logic [1:0] rm_field,
   output arith_rm_e  rm_out
);
   always_comb begin
      unique case (rm_field)
         2'd0:    rm_out = ARM_NEAR_EVEN;
         2'd1:    rm_out = ARM_TO_ZERO;
         2'd2:    rm_out = ARM_TO_PLUS;
         default: rm_out = ARM_TO_MINUS;
      endcase
   end
endmodule

// File: rtl/vcr_trap_detect.sv
module vcr_trap_detect
   import vcr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [CSR_W-1:0] wr_val,
   output logic             trap_q
);
   logic [N_CAUSE-1:0] cause;
   logic [N_CAUSE-1:0] armed;
   logic               hit;

   assign cause = wr_val[CAUSE_LSB +: N_CAUSE];
   assign armed = {1'b1, wr_val[EN_LSB +: N_EN]};
   assign hit   = |(cause & armed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trap_q <= 1'b0;
      else        trap_q <= commit & hit;
   end
endmodule

// File: rtl/vcr_read_mux.sv
module vcr_read_mux
   import vcr_pkg::*;
#(
   parameter int               GPR_W      = 32,
   parameter int               IDX_W      = 5,
   parameter logic [GPR_W-1:0] IMPL_VALUE = '0
) (
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [CSR_W-1:0] csr_q,
   output logic [GPR_W-1:0] rd_data
);
   logic [GPR_W-1:0] csr_wide;

   generate
      if (GPR_W > CSR_W) begin : g_pad
         assign csr_wide = {{(GPR_W-CSR_W){1'b0}}, csr_q};
      end else begin : g_exact
         assign csr_wide = csr_q;
      end
   endgenerate

   always_comb begin
      if (rd_idx == IDX_W'(0))      rd_data = IMPL_VALUE;
      else if (rd_idx == IDX_W'(1)) rd_data = csr_wide;
      else                          rd_data = '0;
   end
endmodule

// File: rtl/vcr_ctl_access.sv
module vcr_ctl_access
   import vcr_pkg::*;
#(
   parameter int               GPR_W      = 32,
   parameter int               IDX_W      = 5,
   parameter logic [GPR_W-1:0] IMPL_VALUE = GPR_W'(32'h0000_1207)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [GPR_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [GPR_W-1:0] rd_data,
   output logic [1:0]       round_mode,
   output logic             flush_out,
   output logic             flush_in,
   output logic             trap
);
   generate
      if (GPR_W < CSR_W) begin : g_bad_width
         $error("GPR_W must hold the full control word");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("IDX_W must be at least 1");
      end
   endgenerate

   logic             commit;
   logic [CSR_W-1:0] wr_val;
   logic [CSR_W-1:0] csr_q;
   arith_rm_e        rm_enc;
   logic             unused_hi;

   assign commit    = wr_en && (wr_idx == IDX_W'(1));
   assign wr_val    = wr_data[CSR_W-1:0];
   assign unused_hi = ^{1'b0, wr_data};

   vcr_csr_store u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit),
      .wr_val (wr_val),
      .csr_q  (csr_q)
   );

   vcr_trap_detect u_trap (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit),
      .wr_val (wr_val),
      .trap_q (trap)
   );

   vcr_round_xlate u_rm (
      .rm_field (csr_q[RM_LSB +: 2]),
      .rm_out   (rm_enc)
   );

   vcr_read_mux #(
      .GPR_W      (GPR_W),
      .IDX_W      (IDX_W),
      .IMPL_VALUE (IMPL_VALUE)
   ) u_rd (
      .rd_idx  (rd_idx),
      .csr_q   (csr_q),
      .rd_data (rd_data)
   );

   assign round_mode = rm_enc;
   assign flush_out  = csr_q[FLUSH_BIT];
   assign flush_in   = csr_q[FLUSH_BIT];
endmodule

// File: rtl/vcr_ctl_access_chk.sv
module vcr_ctl_access_chk
   import vcr_pkg::*;
#(
   parameter int               GPR_W      = 32,
   parameter int               IDX_W      = 5,
   parameter logic [GPR_W-1:0] IMPL_VALUE = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic [GPR_W-1:0] wr_data,
   input logic [IDX_W-1:0] rd_idx,
   input logic [GPR_W-1:0] rd_data,
   input logic [1:0]       round_mode,
   input logic             flush_out,
   input logic             flush_in,
   input logic             trap,
   input logic [CSR_W-1:0] csr_q
);
   logic wr_one;
   assign wr_one = wr_en && (wr_idx == IDX_W'(1));

   p_store_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_one |=> csr_q == ($past(wr_data[CSR_W-1:0]) & CSR_MASK));

   p_ignore_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != IDX_W'(1)) |=> $stable(csr_q));

   p_read_impl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == IDX_W'(0)) |-> rd_data == IMPL_VALUE);

   p_read_other_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx > IDX_W'(1)) |-> rd_data == '0);

   p_round_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_one && wr_data[1:0] == 2'd1) |=> round_mode == 2'b11);

   p_flush_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_one |=> (flush_out == $past(wr_data[FLUSH_BIT]))
                 && (flush_in == $past(wr_data[FLUSH_BIT])));

   p_trap_unimpl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_one && wr_data[CAUSE_MSB]) |=> trap);

   p_trap_commits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> (csr_q[CAUSE_MSB:CAUSE_LSB] != '0));

   p_trap_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> $past(wr_one));
endmodule

bind vcr_ctl_access vcr_ctl_access_chk #(
   .GPR_W      (GPR_W),
   .IDX_W      (IDX_W),
   .IMPL_VALUE (IMPL_VALUE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .wr_data    (wr_data),
   .rd_idx     (rd_idx),
   .rd_data    (rd_data),
   .round_mode (round_mode),
   .flush_out  (flush_out),
   .flush_in   (flush_in),
   .trap       (trap),
   .csr_q      (csr_q)
);

// File: tb/vcr_ctl_access_tb.sv
module vcr_ctl_access_tb;
   localparam int          GPR_W = 32;
   localparam int          IDX_W = 5;
   localparam logic [31:0] IMPL  = 32'h0000_1207;
   localparam logic [31:0] MASK  = 32'h0103_FFFF;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [IDX_W-1:0] wr_idx = '0;
   logic [GPR_W-1:0] wr_data = '0;
   logic [IDX_W-1:0] rd_idx = '0;
   logic [GPR_W-1:0] rd_data;
   logic [1:0]       round_mode;
   logic             flush_out, flush_in, trap;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   typedef struct {
      int          due;
      string       req;
      logic [31:0] rd;
      logic [1:0]  rm;
      logic        fl;
      logic        tr;
   } exp_t;
   exp_t sb[$];

   logic [31:0] csr_m = '0;
   logic        trap_m = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   vcr_ctl_access #(.GPR_W(GPR_W), .IDX_W(IDX_W), .IMPL_VALUE(IMPL)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .round_mode(round_mode), .flush_out(flush_out), .flush_in(flush_in),
      .trap(trap)
   );

   function automatic logic [1:0] rm_map(input logic [1:0] f);
      case (f)
         2'd0:    return 2'b00;
         2'd1:    return 2'b11;
         2'd2:    return 2'b10;
         default: return 2'b01;
      endcase
   endfunction

   // Driver: one cycle of stimulus, expected outputs queued for that cycle
   task automatic step(input logic we, input int widx, input logic [31:0] d,
                       input int ridx, input string req);
      exp_t e;
      logic [5:0] cz;
      logic [5:0] en;
      @(negedge clk);
      wr_en   = we;
      wr_idx  = IDX_W'(widx);
      wr_data = d;
      rd_idx  = IDX_W'(ridx);
      e.due = cyc;
      e.req = req;
      e.rd  = (ridx == 0) ? IMPL : (ridx == 1) ? csr_m : 32'h0;
      e.rm  = rm_map(csr_m[1:0]);
      e.fl  = csr_m[24];
      e.tr  = trap_m;
      sb.push_back(e);
      if (we && widx == 1) begin
         cz = d[17:12];
         en = {1'b1, d[11:7]};
         csr_m  = d & MASK;
         trap_m = |(cz & en);
      end else begin
         trap_m = 1'b0;
      end
   endtask

   task automatic idle(input int ridx, input string req);
      step(1'b0, 0, 32'h0, ridx, req);
   endtask

   task automatic cmp(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Monitor
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            cmp(e.req, "rd_data", rd_data, e.rd);
            cmp(e.req, "round_mode", {30'h0, round_mode}, {30'h0, e.rm});
            cmp(e.req, "flush_out", {31'h0, flush_out}, {31'h0, e.fl});
            cmp(e.req, "flush_in", {31'h0, flush_in}, {31'h0, e.fl});
            cmp(e.req, "trap", {31'h0, trap}, {31'h0, e.tr});
         end
      end
   end

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, R4 implementation word
      idle(1, "R1");
      idle(0, "R4");
      // R2 masked store with all bits set (also traps: R7)
      step(1'b1, 1, 32'hFFFF_FFFF, 1, "R2");
      idle(1, "R2");
      // R3 writes to index 0 and 5 are ignored
      step(1'b1, 0, 32'h0000_0001, 1, "R3");
      step(1'b1, 5, 32'h0000_0002, 1, "R3");
      idle(1, "R3");
      idle(7, "R4");
      idle(2, "R4");
      // R5 each rounding field value
      for (int i = 0; i < 4; i++) begin
         step(1'b1, 1, 32'(i), 1, "R5");
         idle(1, "R5");
      end
      // R6 flush bit on then off
      step(1'b1, 1, 32'h0100_0002, 1, "R6");
      idle(1, "R6");
      step(1'b1, 1, 32'h0000_0000, 1, "R6");
      idle(1, "R6");
      // R7 enabled cause traps; R8 value kept; R9 pulse ends
      step(1'b1, 1, 32'h0000_1080, 1, "R7");
      idle(1, "R8");
      idle(1, "R9");
      // R7 cause without its enable: no trap
      step(1'b1, 1, 32'h0000_1100, 1, "R7");
      idle(1, "R7");
      // R7 unimplemented cause traps with no enable
      step(1'b1, 1, 32'h0002_0000, 1, "R7");
      idle(1, "R8");
      // R4 write and read of index 1 in the same cycle
      step(1'b1, 1, 32'h0000_0055, 1, "R4");
      idle(1, "R4");
      // R9 back-to-back trapping writes, then a quiet write
      step(1'b1, 1, 32'h0000_2100, 1, "R9");
      step(1'b1, 1, 32'h0002_0003, 1, "R9");
      step(1'b1, 1, 32'h0000_0000, 1, "R9");
      idle(1, "R9");
      // R9 write to other index right after a trap: no new pulse
      step(1'b1, 1, 32'h0002_0000, 0, "R9");
      step(1'b1, 3, 32'h0002_0000, 1, "R9");
      idle(1, "R9");
      idle(1, "R9");
      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule